// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block sits on a memory bus between an upstream requester and a downstream memory port. It recognises two alias windows of 32 MB each. Every 32-bit word inside a window stands for a single bit of an underlying memory region. A read of such a word fetches the bytes that contain the bit and returns that bit alone. A write of such a word sets or clears that bit through a read-modify-write on the downstream port. Any other access, and every access while aliasing is switched off, goes to the downstream port unchanged.

The window offset selects both the target byte address and the bit. The byte address is the window's target base ORed with the low 25 offset bits shifted right by five, then rounded down to the access size. The bit index is the word number (offset bits 6:2), masked to the number of bits in the access. Only one transaction is in flight at a time, so a read-modify-write cannot be split by a second request. A downstream error ends the transaction and is returned to the requester.

Top module: `bitband_bridge`

## Requirements
- R1: For an alias access the downstream address is TARGET | (addr[24:0] >> 5), with the low bits cleared to align it to the access size. The downstream size is the normalised upstream size.
- R2: An alias read returns the selected bit in bit 0 and zeros in bits 31:1. The bit index is addr[6:2] masked with (8*bytes-1). The bit is bit (index & 7) of fetched byte (index >> 3).
- R3: An alias write issues one downstream read and then one downstream write to the same address and size. The written data equals the fetched data with the selected bit forced to bit 0 of the upstream write data. All other bits keep their fetched values.
- R4: If the downstream read returns an error, the response carries the error with rdata 0, and no downstream write is issued.
- R5: An error on the write-back of an alias write is returned in the response, with rdata 0.
- R6: Alias window 0x2200_0000 maps to target 0x2000_0000, and alias window 0x4200_0000 maps to target 0x4000_0000.
- R7: With cfg_alias_en low, addresses inside the alias windows are not decoded. The access passes downstream unchanged: same address, size, write flag and data. A read returns the raw downstream data.
- R8: With aliasing enabled, an address outside both windows passes downstream unchanged as a single transaction.
- R9: up_req_ready is low from the acceptance of a request until after its response. up_rsp_valid is a one-cycle pulse. A downstream request holds its address and direction until it is accepted.
- R10: After reset, up_req_ready is high, and dn_req_valid and up_rsp_valid are low.
- R11: Size codes mean 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Code 3 is treated as 4 bytes. Fetched bytes are little-endian, with byte 0 in data bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_alias_en | input | 1 | Enables decoding of both alias windows |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request accepted when high with valid |
| up_req_addr | input | 32 | Upstream byte address |
| up_req_write | input | 1 | Upstream write flag |
| up_req_size | input | 2 | Upstream size code |
| up_req_wdata | input | 32 | Upstream write data |
| up_rsp_valid | output | 1 | Upstream response pulse |
| up_rsp_rdata | output | 32 | Upstream read data |
| up_rsp_err | output | 1 | Upstream response error |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_addr | output | 32 | Downstream byte address |
| dn_req_write | output | 1 | Downstream write flag |
| dn_req_size | output | 2 | Downstream size code |
| dn_req_wdata | output | 32 | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream response valid, at least one cycle after acceptance |
| dn_rsp_rdata | input | 32 | Downstream read data, little-endian in the low bytes |
| dn_rsp_err | input | 1 | Downstream response error |

## Verification
Random alias reads and writes go to both windows with all size codes, over a small offset range, so that writes hit bits that are later read back. This separates wrong bit-index masking from wrong byte or address mapping. Directed accesses use word numbers above 7 and above 15 with 1- and 2-byte sizes, which exposes a missing size mask. Random read and write-back errors, with a count of downstream writes, tell a suppressed write-back apart from a propagated one. Accesses with aliasing off, and accesses outside the windows, must arrive downstream untouched, which shows that no decode leaks through.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_WR_REQ  = 3'd3,
    ST_WR_WAIT = 3'd4,
    ST_RESP    = 3'd5
  } bb_state_e;

  // code 3 behaves as a 4-byte access
  function automatic logic [1:0] bb_norm_size(input logic [1:0] s);
    return (s == 2'd3) ? 2'd2 : s;
  endfunction

endpackage

// File: rtl/bb_rst_sync.sv
module bb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bb_window_decode.sv
module bb_window_decode
  import bb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_WIN   = 2,
  parameter int WIN_OFF_W = 25,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] TARGET_BASES = {32'h4000_0000, 32'h2000_0000},
  localparam int BIT_IDX_W = $clog2(DATA_W)
) (
  input  logic                 alias_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           size,
  output logic                 hit,
  output logic [ADDR_W-1:0]    tgt_addr,
  output logic [BIT_IDX_W-1:0] bit_idx
);
  localparam int WORD_SH = $clog2(DATA_W / 8);     // alias word -> bit
  localparam int BIT_SH  = $clog2(DATA_W);         // alias bytes per target byte
  localparam logic [ADDR_W-1:0] WIN_MASK = ~((ADDR_W'(1) << WIN_OFF_W) - ADDR_W'(1));

  logic [NUM_WIN-1:0]             win_hit;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_tgt;
  logic [1:0]                     nsize;
  logic [ADDR_W-1:0]              align_mask;
  logic [BIT_IDX_W-1:0]           idx_mask;
  logic [ADDR_W-1:0]              raw_tgt;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    assign win_hit[i] = alias_en &&
                        ((addr & WIN_MASK) == ALIAS_BASES[i*ADDR_W +: ADDR_W]);
    assign win_tgt[i] = TARGET_BASES[i*ADDR_W +: ADDR_W] |
                        (ADDR_W'(addr[WIN_OFF_W-1:0]) >> BIT_SH);
  end

  always_comb begin
    hit     = 1'b0;
    raw_tgt = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (win_hit[i] && !hit) begin
        hit     = 1'b1;
        raw_tgt = win_tgt[i];
      end
    end
  end

  always_comb begin
    nsize = bb_norm_size(size);
    case (nsize)
      2'd0:    begin align_mask = '1;                idx_mask = BIT_IDX_W'(7);  end
      2'd1:    begin align_mask = ~ADDR_W'(1);       idx_mask = BIT_IDX_W'(15); end
      default: begin align_mask = ~ADDR_W'(3);       idx_mask = BIT_IDX_W'(31); end
    endcase
  end

  assign tgt_addr = raw_tgt & align_mask;
  assign bit_idx  = addr[WORD_SH +: BIT_IDX_W] & idx_mask;
endmodule

// File: rtl/bb_bit_lane.sv
module bb_bit_lane #(
  parameter int DATA_W = 32,
  localparam int BIT_IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]    fetched,
  input  logic [BIT_IDX_W-1:0] bit_idx,
  input  logic [1:0]           size,
  input  logic                 set_val,
  output logic                 sel_bit,
  output logic [DATA_W-1:0]    merged
);
  logic [DATA_W-1:0] one_hot;
  logic [DATA_W-1:0] lane_mask;

  always_comb begin
    one_hot = DATA_W'(1) << bit_idx;
    case (size)
      2'd0:    lane_mask = DATA_W'(8'hFF);
      2'd1:    lane_mask = DATA_W'(16'hFFFF);
      default: lane_mask = '1;
    endcase
    sel_bit = fetched[bit_idx];
    merged  = ((fetched & ~one_hot) | (set_val ? one_hot : '0)) & lane_mask;
  end
endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      up_fire,
  input  logic      req_alias,
  input  logic      req_write,
  input  logic      held_alias,
  input  logic      held_write,
  input  logic      dn_req_ready,
  input  logic      dn_rsp_valid,
  input  logic      dn_rsp_err,
  output bb_state_e state
);
  bb_state_e state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:
        if (up_fire) state_nx = (!req_alias && req_write) ? ST_WR_REQ : ST_RD_REQ;
      ST_RD_REQ:
        if (dn_req_ready) state_nx = ST_RD_WAIT;
      ST_RD_WAIT:
        if (dn_rsp_valid) begin
          if (!dn_rsp_err && held_alias && held_write) state_nx = ST_WR_REQ;
          else                                         state_nx = ST_RESP;
        end
      ST_WR_REQ:
        if (dn_req_ready) state_nx = ST_WR_WAIT;
      ST_WR_WAIT:
        if (dn_rsp_valid) state_nx = ST_RESP;
      ST_RESP:
        state_nx = ST_IDLE;
      default:
        state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_WIN   = 2,
  parameter int WIN_OFF_W = 25,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] TARGET_BASES = {32'h4000_0000, 32'h2000_0000},
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_alias_en,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic [ADDR_W-1:0] up_req_addr,
  input  logic              up_req_write,
  input  logic [1:0]        up_req_size,
  input  logic [DATA_W-1:0] up_req_wdata,
  output logic              up_rsp_valid,
  output logic [DATA_W-1:0] up_rsp_rdata,
  output logic              up_rsp_err,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic [ADDR_W-1:0] dn_req_addr,
  output logic              dn_req_write,
  output logic [1:0]        dn_req_size,
  output logic [DATA_W-1:0] dn_req_wdata,
  input  logic              dn_rsp_valid,
  input  logic [DATA_W-1:0] dn_rsp_rdata,
  input  logic              dn_rsp_err
);
  localparam int BIT_IDX_W = $clog2(DATA_W);

  logic                 srst_n;
  bb_state_e            state;
  logic                 dec_hit;
  logic [ADDR_W-1:0]    dec_tgt;
  logic [BIT_IDX_W-1:0] dec_idx;
  logic                 lane_bit;
  logic [DATA_W-1:0]    lane_merged;

  logic                 alias_q, write_q, setval_q, err_q;
  logic [1:0]           size_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wdata_q, rdata_q;
  logic [BIT_IDX_W-1:0] idx_q;

  logic                 up_fire, rd_done, wr_done;

  bb_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  bb_window_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .WIN_OFF_W(WIN_OFF_W),
    .ALIAS_BASES(ALIAS_BASES), .TARGET_BASES(TARGET_BASES)
  ) u_dec (
    .alias_en(cfg_alias_en), .addr(up_req_addr), .size(up_req_size),
    .hit(dec_hit), .tgt_addr(dec_tgt), .bit_idx(dec_idx)
  );

  bb_bit_lane #(.DATA_W(DATA_W)) u_lane (
    .fetched(dn_rsp_rdata), .bit_idx(idx_q), .size(size_q), .set_val(setval_q),
    .sel_bit(lane_bit), .merged(lane_merged)
  );

  bb_seq u_seq (
    .clk(clk), .rst_n(srst_n), .up_fire(up_fire),
    .req_alias(dec_hit), .req_write(up_req_write),
    .held_alias(alias_q), .held_write(write_q),
    .dn_req_ready(dn_req_ready), .dn_rsp_valid(dn_rsp_valid), .dn_rsp_err(dn_rsp_err),
    .state(state)
  );

  assign up_fire = (state == ST_IDLE) && up_req_valid;
  assign rd_done = (state == ST_RD_WAIT) && dn_rsp_valid;
  assign wr_done = (state == ST_WR_WAIT) && dn_rsp_valid;

  // request capture
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      alias_q  <= 1'b0;
      write_q  <= 1'b0;
      setval_q <= 1'b0;
      size_q   <= '0;
      addr_q   <= '0;
      idx_q    <= '0;
    end else if (up_fire) begin
      alias_q  <= dec_hit;
      write_q  <= up_req_write;
      setval_q <= up_req_wdata[0];
      size_q   <= dec_hit ? bb_norm_size(up_req_size) : up_req_size;
      addr_q   <= dec_hit ? dec_tgt : up_req_addr;
      idx_q    <= dec_idx;
    end
  end

  // write data: upstream data, or the merged word after the fetch
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      wdata_q <= '0;
    end else if (up_fire) begin
      wdata_q <= up_req_wdata;
    end else if (rd_done && alias_q && write_q && !dn_rsp_err) begin
      wdata_q <= lane_merged;
    end
  end

  // response capture
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (rd_done) begin
      err_q <= dn_rsp_err;
      if (dn_rsp_err || (alias_q && write_q)) rdata_q <= '0;
      else if (alias_q)                       rdata_q <= DATA_W'(lane_bit);
      else                                    rdata_q <= dn_rsp_rdata;
    end else if (wr_done) begin
      err_q   <= dn_rsp_err;
      rdata_q <= '0;
    end
  end

  assign up_req_ready = (state == ST_IDLE);
  assign up_rsp_valid = (state == ST_RESP);
  assign up_rsp_rdata = up_rsp_valid ? rdata_q : '0;
  assign up_rsp_err   = up_rsp_valid & err_q;

  assign dn_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign dn_req_write = (state == ST_WR_REQ);
  assign dn_req_addr  = addr_q;
  assign dn_req_size  = size_q;
  assign dn_req_wdata = dn_req_write ? wdata_q : '0;
endmodule

// File: rtl/bb_bridge_chk.sv
module bb_bridge_chk
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              srst_n,
  input bb_state_e         state,
  input logic              alias_q,
  input logic              up_req_ready,
  input logic              up_rsp_valid,
  input logic [DATA_W-1:0] up_rsp_rdata,
  input logic              dn_req_valid,
  input logic              dn_req_ready,
  input logic [ADDR_W-1:0] dn_req_addr,
  input logic              dn_req_write,
  input logic [1:0]        dn_req_size,
  input logic              dn_rsp_valid,
  input logic              dn_rsp_err
);
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    up_rsp_valid |=> !up_rsp_valid);

  // R9
  no_accept_in_rsp_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(up_req_ready && up_rsp_valid));

  // R9
  dn_req_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (dn_req_valid && !dn_req_ready) |=>
      (dn_req_valid && $stable(dn_req_addr) && $stable(dn_req_write)));

  // R1
  alias_align_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (dn_req_valid && alias_q) |->
      ((dn_req_size == 2'd0) ||
       (dn_req_size == 2'd1 && !dn_req_addr[0]) ||
       (dn_req_size[1] && dn_req_addr[1:0] == 2'b00)));

  // R2
  alias_rdata_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (up_rsp_valid && alias_q) |-> (up_rsp_rdata[DATA_W-1:1] == '0));

  // R4
  no_wb_after_err_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_RD_WAIT && dn_rsp_valid && dn_rsp_err) |=> !dn_req_valid);
endmodule

bind bitband_bridge bb_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .srst_n(srst_n), .state(state), .alias_q(alias_q),
  .up_req_ready(up_req_ready), .up_rsp_valid(up_rsp_valid), .up_rsp_rdata(up_rsp_rdata),
  .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready), .dn_req_addr(dn_req_addr),
  .dn_req_write(dn_req_write), .dn_req_size(dn_req_size),
  .dn_rsp_valid(dn_rsp_valid), .dn_rsp_err(dn_rsp_err)
);

// File: tb/bitband_bridge_tb.sv
`timescale 1ns/1ps
module bitband_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_alias_en;
  logic        up_req_valid, up_req_ready, up_req_write;
  logic [31:0] up_req_addr, up_req_wdata;
  logic [1:0]  up_req_size;
  logic        up_rsp_valid, up_rsp_err;
  logic [31:0] up_rsp_rdata;
  logic        dn_req_valid, dn_req_ready, dn_req_write;
  logic [31:0] dn_req_addr, dn_req_wdata;
  logic [1:0]  dn_req_size;
  logic        dn_rsp_valid, dn_rsp_err;
  logic [31:0] dn_rsp_rdata;

  always #4 clk = ~clk;

  bitband_bridge u_dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] mem  [logic [31:0]];
  logic [7:0] refm [logic [31:0]];
  int          dn_rd_cnt = 0, dn_wr_cnt = 0;
  logic [31:0] last_rd_addr, last_wr_addr, last_wr_data;
  logic [1:0]  last_rd_size, last_wr_size;
  logic        inj_rd_err = 0, inj_wr_err = 0;

  function automatic logic [7:0] seed_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] mem_get(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : seed_byte(a);
  endfunction
  function automatic logic [7:0] ref_get(input logic [31:0] a);
    return refm.exists(a) ? refm[a] : seed_byte(a);
  endfunction
  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction
  function automatic logic [31:0] ref_word(input logic [31:0] a, input int n);
    logic [31:0] w = '0;
    for (int k = 0; k < n; k++) w[8*k +: 8] = ref_get(a + k);
    return w;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // downstream memory model
  initial begin
    int lat, n;
    logic [31:0] ca, cd, rd;
    logic cw, e;
    logic [1:0] cs;
    dn_req_ready = 0; dn_rsp_valid = 0; dn_rsp_rdata = '0; dn_rsp_err = 0;
    forever begin
      @(negedge clk);
      if (dn_req_valid) begin
        lat = $urandom % 3;
        repeat (lat) @(negedge clk);
        dn_req_ready = 1;
        ca = dn_req_addr; cw = dn_req_write; cs = dn_req_size; cd = dn_req_wdata;
        @(negedge clk);
        dn_req_ready = 0;
        lat = $urandom % 3;
        repeat (lat) @(negedge clk);
        n = nbytes(cs);
        rd = '0;
        if (cw) begin
          e = inj_wr_err;
          dn_wr_cnt++; last_wr_addr = ca; last_wr_data = cd; last_wr_size = cs;
          if (!e) for (int k = 0; k < n; k++) mem[ca + k] = cd[8*k +: 8];
        end else begin
          e = inj_rd_err;
          dn_rd_cnt++; last_rd_addr = ca; last_rd_size = cs;
          if (!e) for (int k = 0; k < n; k++) rd[8*k +: 8] = mem_get(ca + k);
        end
        dn_rsp_valid = 1; dn_rsp_err = e; dn_rsp_rdata = rd;
        @(negedge clk);
        dn_rsp_valid = 0; dn_rsp_err = 0; dn_rsp_rdata = '0;
      end
    end
  end

  task automatic access(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output logic er);
    bit held_bad = 0;
    @(negedge clk);
    while (!up_req_ready) @(negedge clk);
    up_req_valid = 1; up_req_addr = a; up_req_write = wr;
    up_req_size = sz; up_req_wdata = wd;
    @(negedge clk);
    up_req_valid = 0;
    while (!up_rsp_valid) begin
      if (up_req_ready) held_bad = 1;
      @(negedge clk);
    end
    rd = up_rsp_rdata; er = up_rsp_err;
    @(negedge clk);
    chk("R9", "ready during transaction / response pulse",
        {30'b0, held_bad, up_rsp_valid}, 32'h0);
  endtask

  // one access checked against the bench model
  task automatic run(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                     input logic [31:0] wd, input logic re, input logic we,
                     input string tag);
    logic [31:0] rd, tgt, al, expw;
    logic er, win, isal;
    int n, idx, rd0, wr0;
    logic [7:0] b;
    inj_rd_err = re; inj_wr_err = we;
    rd0 = dn_rd_cnt; wr0 = dn_wr_cnt;
    win = (a[31:25] == 7'h11) || (a[31:25] == 7'h21);
    isal = cfg_alias_en && win;
    access(a, wr, sz, wd, rd, er);
    n = nbytes(sz);
    if (isal) begin
      tgt = ((a[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000) | (a[24:0] >> 5);
      al  = tgt & ~(n - 1);
      idx = int'(a[6:2]) & (8*n - 1);
      chk(tag, "R1/R6 downstream read address", last_rd_addr, al);
      chk(tag, "R11 downstream size", {30'b0, last_rd_size}, {30'b0, (sz == 2'd3) ? 2'd2 : sz});
      if (!wr) begin
        b = ref_get(al + idx/8);
        chk(tag, "R2 alias read data", rd, re ? 32'h0 : {31'b0, b[idx%8]});
        chk(tag, "R4 read error flag", {31'b0, er}, {31'b0, re});
        chk(tag, "R4 no write on read", dn_wr_cnt - wr0, 0);
      end else begin
        chk(tag, "R4 write-back suppressed on read error", dn_wr_cnt - wr0, re ? 0 : 1);
        chk(tag, "R5 write error flag", {31'b0, er}, {31'b0, re | we});
        chk(tag, "R5 write response data", rd, 32'h0);
        if (!re) begin
          expw = ref_word(al, n);
          expw[idx] = wd[0];
          chk(tag, "R3 write-back address", last_wr_addr, al);
          chk(tag, "R3 write-back data", last_wr_data, expw);
          if (!we) for (int k = 0; k < n; k++) refm[al + k] = expw[8*k +: 8];
          for (int k = 0; k < n; k++)
            chk(tag, "R3 memory byte", {24'b0, mem_get(al + k)}, {24'b0, ref_get(al + k)});
        end
      end
    end else begin
      if (!wr) begin
        chk(tag, "R7/R8 pass read address", last_rd_addr, a);
        chk(tag, "R7/R8 pass read data", rd, re ? 32'h0 : ref_word(a, n));
        chk(tag, "R7/R8 single transaction", dn_rd_cnt - rd0 + dn_wr_cnt - wr0, 1);
      end else begin
        chk(tag, "R7/R8 pass write address", last_wr_addr, a);
        chk(tag, "R7/R8 pass write data", last_wr_data, wd);
        chk(tag, "R7/R8 pass write size", {30'b0, last_wr_size}, {30'b0, sz});
        chk(tag, "R7/R8 single transaction", dn_rd_cnt - rd0 + dn_wr_cnt - wr0, 1);
        if (!we) for (int k = 0; k < n; k++) refm[a + k] = wd[8*k +: 8];
      end
      chk(tag, "R7/R8 error flag", {31'b0, er}, {31'b0, wr ? we : re});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    int w;
    void'($urandom(32'd20240611));
    rst_n = 0; cfg_alias_en = 1; up_req_valid = 0; up_req_addr = '0;
    up_req_write = 0; up_req_size = 2'd2; up_req_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R10", "ready after reset", {31'b0, up_req_ready}, 32'h1);
    chk("R10", "dn valid after reset", {31'b0, dn_req_valid}, 32'h0);
    chk("R10", "rsp valid after reset", {31'b0, up_rsp_valid}, 32'h0);

    // directed: R2 word 37 -> byte 4 (4-byte aligned 0x2000_0004), bit 5
    run(32'h2200_0000 + (37 << 2), 0, 2'd2, 0, 0, 0, "R2");
    run(32'h2200_0000 + (37 << 2), 1, 2'd2, 1, 0, 0, "R3");
    run(32'h2200_0000 + (37 << 2), 0, 2'd2, 0, 0, 0, "R3");
    run(32'h2200_0000 + (37 << 2), 1, 2'd2, 0, 0, 0, "R3");
    run(32'h2200_0000 + (37 << 2), 0, 2'd2, 0, 0, 0, "R3");
    // R6 second window
    run(32'h4200_0000 + (1234 << 2), 1, 2'd2, 32'hFFFF_FFFF, 0, 0, "R6");
    run(32'h4200_0000 + (1234 << 2), 0, 2'd2, 0, 0, 0, "R6");
    // R11 byte and halfword sizes, word numbers above the size mask
    run(32'h2200_0000 + (29 << 2), 1, 2'd0, 0, 0, 0, "R11");
    run(32'h2200_0000 + (29 << 2), 0, 2'd0, 0, 0, 0, "R11");
    run(32'h2200_0000 + (27 << 2), 1, 2'd1, 1, 0, 0, "R11");
    run(32'h2200_0000 + (27 << 2), 0, 2'd1, 0, 0, 0, "R11");
    run(32'h4200_0000 + (63 << 2), 0, 2'd3, 0, 0, 0, "R11");
    // errors
    run(32'h2200_0100, 0, 2'd2, 0, 1, 0, "R4");
    run(32'h2200_0100, 1, 2'd2, 1, 1, 0, "R4");
    run(32'h2200_0100, 1, 2'd2, 1, 0, 1, "R5");
    // R7 disabled: alias address passes raw
    cfg_alias_en = 0;
    run(32'h2200_0010, 1, 2'd2, 32'hCAFE_F00D, 0, 0, "R7");
    run(32'h2200_0010, 0, 2'd2, 0, 0, 0, "R7");
    run(32'h4200_0021, 0, 2'd0, 0, 0, 0, "R7");
    cfg_alias_en = 1;
    // R8 enabled, outside windows
    run(32'h3000_0040, 1, 2'd1, 32'h0000_BEEF, 0, 0, "R8");
    run(32'h3000_0040, 0, 2'd2, 0, 0, 0, "R8");
    run(32'h2000_0004, 0, 2'd2, 0, 0, 0, "R8");

    // random mix
    for (int i = 0; i < 400; i++) begin
      w = $urandom % 6;
      cfg_alias_en = (w != 5);
      case (w)
        0, 1, 5: a = 32'h2200_0000 | ($urandom % 4096);
        2, 3:    a = 32'h4200_0000 | ($urandom % 4096);
        default: a = 32'h2000_0000 | ($urandom % 128);
      endcase
      run(a, 1'($urandom), 2'($urandom), $urandom,
          ($urandom % 10) == 0, ($urandom % 10) == 0, "RND");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule